// File: doc/BRIEF.md
# System-Clock Watchdog Timer with Wakeup Output

This block is a down-counting watchdog clocked by the system clock. Software reaches it through a small register bus with three word addresses: a reload register, a read-only live counter, and a control word. The live counter is never loaded with bus data. Writing the reload register copies the written value into both registers. Any write to the live-counter address refills the live counter from the reload register, and the write data is ignored.

While a two-bit event field in the control word selects an event, the live counter drops by one on every clock. It halts when it reaches zero and does not wrap. When the counter steps from one to zero, the block does three things. It emits a one-cycle request on the reset, NMI or general interrupt line, whichever the event field selects. It sets a sticky expired flag in bit 15 of the control word. It drives a level wakeup output for the power controller, and that output stays high until software clears the flag.

Writing 1 to bit 15 clears the flag. Setting the event field to 11 stops the timer. Software usually writes 0x8006 to acknowledge an expiry and disable the timer, and 0x0004 to arm the timer with an interrupt.

Top module: `wdt_top`

## Requirements
- R1: After reset the live counter and the reload register read 0, the control word reads 0x0006 (timer stopped, flag clear), and all event outputs and `wake_o` are low.
- R2: A write to address 0 (reload) stores the data in the reload register and loads the same value into the live counter. Both values are visible on the next cycle.
- R3: A write to address 1 (live counter) refills the live counter from the reload register. The write data has no effect.
- R4: The event field is control bits [2:1]. When it is not 11, the live counter decreases by exactly one per clock. When it is 11, the counter holds its value.
- R5: The live counter stops at zero. It does not wrap, and it raises no further event while it stays at zero. Loading zero through a bus write raises no event.
- R6: When a decrement takes the counter from one to zero, exactly one event output pulses for one cycle, in the same cycle that zero appears. Event field 00 pulses `evt_rst_o`, 01 pulses `evt_nmi_o` and 10 pulses `evt_irq_o`.
- R7: Expiry sets control bit 15. The bit stays set through further counting and through control writes that have 0 in bit 15. A control write with 1 in bit 15 clears it. If a clear and an expiry happen in the same cycle, the expiry wins.
- R8: Writing 0x8006 clears the flag and stops the timer. Writing 0x0004 starts the timer with the general interrupt event.
- R9: `wake_o` is high exactly while the expired flag is set.
- R10: Control bit 0 and bits [14:3] read as zero. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address: 0 reload, 1 live counter, 2 control |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt_rst_o | output | 1 | One-cycle reset request on expiry |
| evt_nmi_o | output | 1 | One-cycle NMI request on expiry |
| evt_irq_o | output | 1 | One-cycle general interrupt request on expiry |
| wake_o | output | 1 | Wakeup request level, mirrors the expired flag |

## Verification
The assertions check these rules on every cycle:
- one decrement per clock while running, and the hold at zero;
- a reload write landing in the counter;
- at most one event line high, and never for two cycles in a row;
- an event only together with a zero count and a set flag;
- the flag surviving every cycle that has no clearing write;
- `wake_o` tracking the flag.

Only the bench scenarios can show the cycle-exact timing of expiry for each event code, that the data written to the live address is ignored, that a stopped timer holds its count, and the effect of the 0x8006 and 0x0004 control values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Event field encoding; 11 also means "timer stopped"
    typedef enum logic [1:0] {
        EV_RESET = 2'b00,
        EV_NMI   = 2'b01,
        EV_IRQ   = 2'b10,
        EV_OFF   = 2'b11
    } wdt_evt_e;

    localparam logic [1:0] ADR_RELOAD = 2'd0;
    localparam logic [1:0] ADR_LIVE   = 2'd1;
    localparam logic [1:0] ADR_CTRL   = 2'd2;

    localparam int FLAG_BIT = 15;
    localparam int CTRL_W   = 16;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_reload,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             rearm,
    input  logic             run,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] reload,
    output logic             hit_zero
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] live;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_t st_d, st_q;
    logic       hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (ld_reload) begin
            st_d.reload = ld_val;
            st_d.live   = ld_val;
        end else if (rearm) begin
            st_d.live = st_q.reload;
        end else if (run && (st_q.live != '0)) begin
            st_d.live = st_q.live - ONE;
            hit_d     = (st_q.live == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live     = st_q.live;
    assign reload   = st_q.reload;
    assign hit_zero = hit_d;

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              hit_zero,
    output logic              run,
    output logic              flag,
    output logic [1:0]        sel,
    output logic              evt_rst,
    output logic              evt_nmi,
    output logic              evt_irq
);

    typedef struct packed {
        wdt_evt_e   sel;
        logic       flag;
        logic [2:0] evt;   // {reset, nmi, irq}
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 3'b000;
        if (ctl_we) begin
            st_d.sel = wdt_evt_e'(ctl_wdata[2:1]);
            if (ctl_wdata[FLAG_BIT]) begin
                st_d.flag = 1'b0;
            end
        end
        if (hit_zero) begin
            st_d.flag = 1'b1;
            unique case (st_q.sel)
                EV_RESET: st_d.evt = 3'b100;
                EV_NMI:   st_d.evt = 3'b010;
                EV_IRQ:   st_d.evt = 3'b001;
                default:  st_d.evt = 3'b000;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= EV_OFF;
            st_q.flag <= 1'b0;
            st_q.evt  <= 3'b000;
        end else begin
            st_q <= st_d;
        end
    end

    assign run     = (st_q.sel != EV_OFF);
    assign flag    = st_q.flag;
    assign sel     = st_q.sel;
    assign evt_rst = st_q.evt[2];
    assign evt_nmi = st_q.evt[1];
    assign evt_irq = st_q.evt[0];

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              evt_rst_o,
    output logic              evt_nmi_o,
    output logic              evt_irq_o,
    output logic              wake_o
);

    localparam int PAD_W = DATA_W - CTRL_W;

    logic             wr_reload, wr_live, wr_ctrl;
    logic [CNT_W-1:0] live_cnt, reload_cnt;
    logic             hit_zero, run, exp_flag;
    logic [1:0]       evt_sel;
    logic [CTRL_W-1:0] ctrl_rd;

    assign wr_reload = bus_we && (bus_addr == ADR_RELOAD);
    assign wr_live   = bus_we && (bus_addr == ADR_LIVE);
    assign wr_ctrl   = bus_we && (bus_addr == ADR_CTRL);

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_reload(wr_reload),
        .ld_val   (bus_wdata[CNT_W-1:0]),
        .rearm    (wr_live),
        .run      (run),
        .live     (live_cnt),
        .reload   (reload_cnt),
        .hit_zero (hit_zero)
    );

    wdt_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (wr_ctrl),
        .ctl_wdata(bus_wdata[CTRL_W-1:0]),
        .hit_zero (hit_zero),
        .run      (run),
        .flag     (exp_flag),
        .sel      (evt_sel),
        .evt_rst  (evt_rst_o),
        .evt_nmi  (evt_nmi_o),
        .evt_irq  (evt_irq_o)
    );

    assign ctrl_rd = {exp_flag, 12'd0, evt_sel, 1'b0};

    always_comb begin
        unique case (bus_addr)
            ADR_RELOAD: bus_rdata = DATA_W'(reload_cnt);
            ADR_LIVE:   bus_rdata = DATA_W'(live_cnt);
            ADR_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl_rd};
            default:    bus_rdata = '0;
        endcase
    end

    assign wake_o = exp_flag;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  live,
    input logic              run,
    input logic              flag,
    input logic              evt_rst,
    input logic              evt_nmi,
    input logic              evt_irq,
    input logic              wake
);

    logic wr_r, wr_l, wr_c_clr, any_evt;
    assign wr_r     = bus_we && (bus_addr == 2'd0);
    assign wr_l     = bus_we && (bus_addr == 2'd1);
    assign wr_c_clr = bus_we && (bus_addr == 2'd2) && bus_wdata[15];
    assign any_evt  = evt_rst || evt_nmi || evt_irq;

    // R2
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_r |=> (live == $past(bus_wdata[CNT_W-1:0])));

    // R4
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (live != '0) && !wr_r && !wr_l) |=> (live == ($past(live) - CNT_W'(1))));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((live == '0) && !wr_r && !wr_l) |=> (live == '0));

    // R6
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_rst, evt_nmi, evt_irq}));

    // R6
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> !any_evt);

    // R6
    evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |-> ((live == '0) && flag));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_c_clr) |=> flag);

    // R9
    wake_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake == flag);

endmodule

bind wdt_top wdt_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .live     (live_cnt),
    .run      (run),
    .flag     (exp_flag),
    .evt_rst  (evt_rst_o),
    .evt_nmi  (evt_nmi_o),
    .evt_irq  (evt_irq_o),
    .wake     (wake_o)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_rst_o, evt_nmi_o, evt_irq_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .evt_rst_o(evt_rst_o),
        .evt_nmi_o(evt_nmi_o),
        .evt_irq_o(evt_irq_o),
        .wake_o   (wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 reload", v, 32'h0);
        rd(2'd1, v); chk("R1 live", v, 32'h0);
        rd(2'd2, v); chk("R1 ctrl", v, 32'h0006);
        chk("R1 outputs", {28'd0, evt_rst_o, evt_nmi_o, evt_irq_o, wake_o}, 32'h0);
    endtask

    task automatic t_load;
        logic [31:0] v;
        wr(2'd0, 32'h30);
        rd(2'd0, v); chk("R2 reload", v, 32'h30);
        rd(2'd1, v); chk("R2 live", v, 32'h30);
        step(3);
        rd(2'd1, v); chk("R4 stopped holds", v, 32'h30);
        wr(2'd2, 32'h0004);
        step(3);
        rd(2'd1, v); chk("R4 decrement", v, 32'h2D);
        rd(2'd2, v); chk("R8 0x0004 arms irq", v, 32'h0004);
        wr(2'd1, 32'h1234);
        rd(2'd1, v); chk("R3 refill ignores data", v, 32'h30);
        rd(2'd0, v); chk("R3 reload kept", v, 32'h30);
        wr(2'd2, 32'h8006);
        rd(2'd1, v); chk("R8 stop", v, 32'h2F);
        step(2);
        rd(2'd1, v); chk("R8 stop holds", v, 32'h2F);
    endtask

    task automatic t_expire(input logic [1:0] code);
        logic [31:0] v;
        logic [2:0]  exp_evt;
        exp_evt = (code == 2'b00) ? 3'b100 : (code == 2'b01) ? 3'b010 : 3'b001;
        wr(2'd2, 32'h8006);
        wr(2'd0, 32'd5);
        wr(2'd2, {29'd0, code, 1'b0});
        step(4);
        rd(2'd1, v); chk("R4 count at one", v, 32'd1);
        chk("R6 no early event", {29'd0, evt_rst_o, evt_nmi_o, evt_irq_o}, 32'd0);
        step(1);
        chk("R6 event line", {29'd0, evt_rst_o, evt_nmi_o, evt_irq_o}, {29'd0, exp_evt});
        rd(2'd1, v); chk("R6 zero with event", v, 32'd0);
        rd(2'd2, v); chk("R7 flag set", v, {16'd0, 1'b1, 12'd0, code, 1'b0});
        chk("R9 wake high", {31'd0, wake_o}, 32'd1);
        step(1);
        chk("R6 single pulse", {29'd0, evt_rst_o, evt_nmi_o, evt_irq_o}, 32'd0);
        step(5);
        rd(2'd1, v); chk("R5 stays zero", v, 32'd0);
        chk("R5 no repeat event", {29'd0, evt_rst_o, evt_nmi_o, evt_irq_o}, 32'd0);
        wr(2'd2, {29'd0, code, 1'b0});
        rd(2'd2, v); chk("R7 write 0 keeps flag", v[15:0], {1'b1, 12'd0, code, 1'b0});
        wr(2'd2, 32'h8006);
        rd(2'd2, v); chk("R8 0x8006 clears", v, 32'h0006);
        chk("R9 wake low", {31'd0, wake_o}, 32'd0);
    endtask

    task automatic t_misc;
        logic [31:0] v;
        wr(2'd2, 32'h7FFF);
        rd(2'd2, v); chk("R10 unused bits zero", v, 32'h0006);
        rd(2'd3, v); chk("R10 addr3 zero", v, 32'h0);
        wr(2'd2, 32'h0002);
        wr(2'd0, 32'd0);
        step(3);
        rd(2'd1, v); chk("R5 zero load no wrap", v, 32'd0);
        chk("R5 zero load no event", {29'd0, evt_rst_o, evt_nmi_o, evt_irq_o}, 32'd0);
        rd(2'd2, v); chk("R5 zero load no flag", v, 32'h0002);
        wr(2'd2, 32'h8006);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_load();
        t_expire(2'b00);
        t_expire(2'b01);
        t_expire(2'b10);
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule